// File: doc/BRIEF.md
# Dual-Width Pulse Generator

This block produces rectangular waveforms whose high and low widths are set independently. Each channel owns an 8-bit down-counter and two 8-bit reload values, one for the low phase and one for the high phase. When the counter reaches zero, the channel flips its output level and reloads from the value that belongs to the new phase. Any duty cycle can therefore be built from two register writes.

Channels come in pairs, and a per-pair mode field decides how a pair behaves. It can act as two separate 8-bit channels. It can act as one 16-bit channel, with the even counter as the low byte. It can also act as an 8-bit divider that paces the odd channel. A shared clock-select field slows the count rate by a power of two. Every channel has a run bit, an output-enable bit and a sticky interrupt flag. The flag rises when a high phase finishes. A plain write/read register port gives software control of all of this.

Top module: `pulsegen_top`

## Requirements
- R1: After a synchronous reset, every pin is low, irq is low and every register reads back zero.
- R2: Register addresses are as follows, with N the channel count. Channel c has its low-width reload at 2c and its high-width reload at 2c+1. The run bits are at 2N and the output enables at 2N+1, one bit per channel. The pair modes are at 2N+2, with pair p in bits 2p+1:2p: 0 means split, 1 means wide, 2 means prescale and 3 behaves as split. The count-rate select is at 2N+3 in bits 1:0. The flags are at 2N+4. Every register reads back what was written, limited to its stored bits.
- R3: A channel that is started always begins in its low phase. With rate select 0, the pin stays low for (low reload + 1) cycles, counted from the clock edge that captures the run bit.
- R4: In split mode with rate select 0, the low phase lasts (low reload + 1) cycles and the high phase lasts (high reload + 1) cycles.
- R5: A rate select of s makes the counters step once every 2^s cycles, so each phase width is multiplied by 2^s.
- R6: In wide mode the odd channel's run bit starts the pair. The low width is ({odd low, even low} + 1)·2^s cycles and the high width is ({odd high, even high} + 1)·2^s cycles. The waveform appears on the odd pin, and the even pin stays low.
- R7: In prescale mode the even counter reloads from its low reload and is used only as a divider. The odd channel's low width is (even low + 1)(odd low + 1)·2^s cycles, and its high width is (even low + 1)(odd high + 1)·2^s cycles. The even high reload is ignored, the even pin stays low, and both run bits must be set.
- R8: A channel's flag sets on the same clock edge that ends one of its high phases, so the flag and the falling pin appear together. In chained modes only the odd flag can set. The irq output is the OR of all flags.
- R9: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. A flag stays set until it is cleared.
- R10: Clearing a run bit drives the pin low in the next cycle and leaves the reload registers unchanged. Setting the run bit again restarts the channel with a full low phase.
- R11: Clearing an output-enable bit holds the pin low. The channel keeps counting and its flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, captured at the rising clock edge |
| bus_addr | input | AW | Register address, shared by writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pwm_out | output | 2·NPAIR | Waveform pins, one per channel |
| irq | output | 1 | OR of all channel flags |

## Verification
A register write takes effect at the rising edge that captures it. Read data is combinational and is sampled one time unit after a falling edge. A cleared run bit shows on its pin at the next falling edge. A started channel's first low phase is counted from the falling edge right after the write. Phase widths are measured only on complete phases: the bench waits for a rising pin, counts falling-edge samples while the pin is high, then counts while it is low. This keeps the start-up alignment of a divided count rate out of the result. A flag is checked at the same falling edge where its pin is first seen low again.

// File: rtl/pulsegen_pkg.sv
package pulsegen_pkg;

    localparam int CW    = 8;
    localparam int SEL_W = 2;
    localparam int DIV_W = (2 ** SEL_W) - 1;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [1:0] {
        MODE_SPLIT    = 2'd0,
        MODE_WIDE     = 2'd1,
        MODE_PRESCALE = 2'd2,
        MODE_SPARE    = 2'd3
    } pair_mode_e;

    typedef struct packed {
        cnt_t cnt;
        logic hi;
    } chan_t;

    typedef struct packed {
        chan_t nxt;
        logic  high_end;
    } step_t;

    // One counting step of an 8-bit channel: flip and reload on zero.
    function automatic step_t chan_step(chan_t s, cnt_t lo, cnt_t hi);
        step_t r;
        r.high_end = 1'b0;
        if (s.cnt == '0) begin
            r.nxt.hi   = ~s.hi;
            r.nxt.cnt  = s.hi ? lo : hi;
            r.high_end = s.hi;
        end else begin
            r.nxt.hi  = s.hi;
            r.nxt.cnt = s.cnt - 1'b1;
        end
        return r;
    endfunction

    // Parked state of a stopped channel: low, loaded with the low width.
    function automatic chan_t chan_idle(cnt_t lo);
        chan_t r;
        r.cnt = lo;
        r.hi  = 1'b0;
        return r;
    endfunction

    // Low-order ones mask selecting one count step every 2^s cycles.
    function automatic logic [DIV_W-1:0] sel_mask(logic [SEL_W-1:0] s);
        logic [DIV_W:0] one_hot;
        one_hot = (DIV_W+1)'(1) << s;
        return one_hot[DIV_W-1:0] - 1'b1;
    endfunction

endpackage

// File: rtl/pulsegen_tick.sv
module pulsegen_tick
    import pulsegen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask = sel_mask(sel);
        tick = ((div_q & mask) == mask);
    end

endmodule

// File: rtl/pulsegen_regs.sv
module pulsegen_regs
    import pulsegen_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = 8,
    localparam int NPAIR = NCH / 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic [NCH-1:0]              set_flag,
    output logic [DW-1:0]               rdata,
    output logic [NCH-1:0][CW-1:0]      rel_lo,
    output logic [NCH-1:0][CW-1:0]      rel_hi,
    output logic [NCH-1:0]              en_q,
    output logic [NCH-1:0]              oe_q,
    output logic [NPAIR-1:0][1:0]       mode_q,
    output logic [SEL_W-1:0]            sel_q,
    output logic [NCH-1:0]              flags_q
);

    localparam logic [AW-1:0] A_EN   = AW'(2 * NCH);
    localparam logic [AW-1:0] A_OE   = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_MODE = AW'(2 * NCH + 2);
    localparam logic [AW-1:0] A_SEL  = AW'(2 * NCH + 3);
    localparam logic [AW-1:0] A_FLAG = AW'(2 * NCH + 4);

    logic [NCH-1:0] clr;

    assign clr = (wr && addr == A_FLAG) ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_lo  <= '0;
            rel_hi  <= '0;
            en_q    <= '0;
            oe_q    <= '0;
            mode_q  <= '0;
            sel_q   <= '0;
            flags_q <= '0;
        end else begin
            // a set in the same cycle as a clear wins
            flags_q <= (flags_q & ~clr) | set_flag;
            if (wr) begin
                for (int c = 0; c < NCH; c++) begin
                    if (addr == AW'(2 * c))     rel_lo[c] <= CW'(wdata);
                    if (addr == AW'(2 * c + 1)) rel_hi[c] <= CW'(wdata);
                end
                if (addr == A_EN)   en_q   <= wdata[NCH-1:0];
                if (addr == A_OE)   oe_q   <= wdata[NCH-1:0];
                if (addr == A_MODE) mode_q <= wdata[2*NPAIR-1:0];
                if (addr == A_SEL)  sel_q  <= wdata[SEL_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(2 * c))     rdata = DW'(rel_lo[c]);
            if (addr == AW'(2 * c + 1)) rdata = DW'(rel_hi[c]);
        end
        if (addr == A_EN)   rdata[NCH-1:0]     = en_q;
        if (addr == A_OE)   rdata[NCH-1:0]     = oe_q;
        if (addr == A_MODE) rdata[2*NPAIR-1:0] = mode_q;
        if (addr == A_SEL)  rdata[SEL_W-1:0]   = sel_q;
        if (addr == A_FLAG) rdata[NCH-1:0]     = flags_q;
    end

endmodule

// File: rtl/pulsegen_pair.sv
module pulsegen_pair
    import pulsegen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] en,
    input  pair_mode_e mode,
    input  cnt_t       lo0,
    input  cnt_t       hi0,
    input  cnt_t       lo1,
    input  cnt_t       hi1,
    output logic [1:0] phase,
    output logic [1:0] high_end
);

    chan_t           s0, s1, n0, n1;
    step_t           st0, st1;
    logic            pre_tick;
    logic [2*CW-1:0] wide_cnt;

    always_comb begin
        n0       = s0;
        n1       = s1;
        st0      = '0;
        st1      = '0;
        high_end = '0;
        pre_tick = 1'b0;
        wide_cnt = {s1.cnt, s0.cnt};
        case (mode)
            MODE_WIDE: begin
                n0.hi = 1'b0;
                if (!en[1]) begin
                    n0.cnt = lo0;
                    n1     = chan_idle(lo1);
                end else if (tick) begin
                    if (wide_cnt == '0) begin
                        n1.hi             = ~s1.hi;
                        {n1.cnt, n0.cnt}  = s1.hi ? {lo1, lo0} : {hi1, hi0};
                        high_end[1]       = s1.hi;
                    end else begin
                        {n1.cnt, n0.cnt}  = wide_cnt - 1'b1;
                    end
                end
            end
            MODE_PRESCALE: begin
                n0.hi = 1'b0;
                if (!en[0]) begin
                    n0.cnt = lo0;
                end else if (tick) begin
                    if (s0.cnt == '0) begin
                        n0.cnt   = lo0;
                        pre_tick = 1'b1;
                    end else begin
                        n0.cnt   = s0.cnt - 1'b1;
                    end
                end
                if (!en[1]) begin
                    n1 = chan_idle(lo1);
                end else if (pre_tick) begin
                    st1         = chan_step(s1, lo1, hi1);
                    n1          = st1.nxt;
                    high_end[1] = st1.high_end;
                end
            end
            default: begin
                if (!en[0]) begin
                    n0 = chan_idle(lo0);
                end else if (tick) begin
                    st0         = chan_step(s0, lo0, hi0);
                    n0          = st0.nxt;
                    high_end[0] = st0.high_end;
                end
                if (!en[1]) begin
                    n1 = chan_idle(lo1);
                end else if (tick) begin
                    st1         = chan_step(s1, lo1, hi1);
                    n1          = st1.nxt;
                    high_end[1] = st1.high_end;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0 <= '0;
            s1 <= '0;
        end else begin
            s0 <= n0;
            s1 <= n1;
        end
    end

    assign phase = {s1.hi, s0.hi};

endmodule

// File: rtl/pulsegen_top.sv
module pulsegen_top
    import pulsegen_pkg::*;
#(
    parameter int NPAIR = 2,
    parameter int DW    = 8,
    localparam int NCH  = 2 * NPAIR,
    localparam int AW   = $clog2(2 * NCH + 5)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic           irq
);

    logic [NCH-1:0][CW-1:0] rel_lo, rel_hi;
    logic [NCH-1:0]         en_q, oe_q, flags_q;
    logic [NPAIR-1:0][1:0]  mode_q;
    logic [SEL_W-1:0]       sel_q;
    logic [NCH-1:0]         phase, high_end;
    logic                   tick;

    pulsegen_regs #(.NCH(NCH), .AW(AW), .DW(DW)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .set_flag (high_end),
        .rdata    (bus_rdata),
        .rel_lo   (rel_lo),
        .rel_hi   (rel_hi),
        .en_q     (en_q),
        .oe_q     (oe_q),
        .mode_q   (mode_q),
        .sel_q    (sel_q),
        .flags_q  (flags_q)
    );

    pulsegen_tick i_tick (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel_q),
        .tick (tick)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pulsegen_pair i_pair (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .en       (en_q[2*p+1:2*p]),
            .mode     (pair_mode_e'(mode_q[p])),
            .lo0      (rel_lo[2*p]),
            .hi0      (rel_hi[2*p]),
            .lo1      (rel_lo[2*p+1]),
            .hi1      (rel_hi[2*p+1]),
            .phase    (phase[2*p+1:2*p]),
            .high_end (high_end[2*p+1:2*p])
        );
    end

    assign pwm_out = phase & en_q & oe_q;
    assign irq     = |flags_q;

endmodule

// File: rtl/pulsegen_chk.sv
module pulsegen_chk #(
    parameter int NPAIR = 2,
    parameter int AW    = 4,
    parameter int DW    = 8,
    localparam int NCH  = 2 * NPAIR
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic [NCH-1:0]        en_q,
    input logic [NPAIR-1:0][1:0] mode_q,
    input logic [NCH-1:0]        phase,
    input logic [NCH-1:0]        flags_q,
    input logic [NCH-1:0]        pwm_out,
    input logic                  irq
);

    localparam logic [AW-1:0] A_FLAG = AW'(2 * NCH + 4);

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_out == '0 && !irq));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R8: a flag rises only right after a high phase
        a_r8_flag_after_high: assert property (@(posedge clk) disable iff (rst)
            $rose(flags_q[c]) |-> $past(phase[c]));

        // R9: a flag is held unless a 1 is written to its bit
        a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (flags_q[c] && !(bus_wr && bus_addr == A_FLAG && bus_wdata[c]))
            |=> flags_q[c]);

        // R10: a stopped channel parks in its low phase
        a_r10_stop_parks_low: assert property (@(posedge clk) disable iff (rst)
            !en_q[c] |=> !phase[c]);
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pr
        // R6 and R7: chained pairs keep the even waveform low
        a_r6_even_phase_quiet: assert property (@(posedge clk) disable iff (rst)
            (mode_q[p] == 2'd1 || mode_q[p] == 2'd2) |=> !phase[2*p]);
    end

endmodule

bind pulsegen_top pulsegen_chk #(.NPAIR(NPAIR), .AW(AW), .DW(DW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .phase     (phase),
    .flags_q   (flags_q),
    .pwm_out   (pwm_out),
    .irq       (irq)
);

// File: tb/test_pulsegen_top.sv
module test_pulsegen_top;

    localparam int NPAIR = 2;
    localparam int NCH   = 2 * NPAIR;
    localparam int AW    = $clog2(2 * NCH + 5);
    localparam logic [AW-1:0] A_EN   = AW'(2 * NCH);
    localparam logic [AW-1:0] A_OE   = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_MODE = AW'(2 * NCH + 2);
    localparam logic [AW-1:0] A_SEL  = AW'(2 * NCH + 3);
    localparam logic [AW-1:0] A_FLAG = AW'(2 * NCH + 4);

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  sel;
        logic [7:0]  lo_e, hi_e, lo_o, hi_o;
        logic [15:0] xlo_e, xhi_e, xlo_o, xhi_o;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 2'd0, 8'd2, 8'd4,   8'd0, 8'd0, 16'd3,  16'd5, 16'd1,   16'd1},
        '{2'd0, 2'd1, 8'd5, 8'd1,   8'd3, 8'd7, 16'd12, 16'd4, 16'd8,   16'd16},
        '{2'd1, 2'd0, 8'd3, 8'd2,   8'd1, 8'd0, 16'd0,  16'd0, 16'd260, 16'd3},
        '{2'd2, 2'd0, 8'd2, 8'd9,   8'd1, 8'd3, 16'd0,  16'd0, 16'd6,   16'd12},
        '{2'd2, 2'd2, 8'd0, 8'd0,   8'd4, 8'd2, 16'd0,  16'd0, 16'd20,  16'd12},
        '{2'd1, 2'd1, 8'd0, 8'hFF,  8'd0, 8'd0, 16'd0,  16'd0, 16'd2,   16'd512}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] pwm_out;
    logic           irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pulsegen_top #(.NPAIR(NPAIR)) i_pulsegen_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Length of one full high phase and the following low phase.
    task automatic measure(input int ch, output int hi_len, output int lo_len);
        @(negedge clk);
        while (pwm_out[ch])  @(negedge clk);
        while (!pwm_out[ch]) @(negedge clk);
        hi_len = 0;
        while (pwm_out[ch])  begin hi_len++; @(negedge clk); end
        lo_len = 0;
        while (!pwm_out[ch]) begin lo_len++; @(negedge clk); end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        int hi_len, lo_len, cnt;
        string tag;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check("R1", "pins after reset", int'(pwm_out), 0);
        check("R1", "irq after reset", int'(irq), 0);
        for (int a = 0; a <= 2 * NCH + 4; a++) begin
            rd(AW'(a), d);
            check("R1", $sformatf("reg %0d after reset", a), int'(d), 0);
        end

        // R2: register readback
        for (int a = 0; a < 2 * NCH; a++) wr(AW'(a), 8'(8'h11 * (a + 1)));
        for (int a = 0; a < 2 * NCH; a++) begin
            rd(AW'(a), d);
            check("R2", $sformatf("reload reg %0d", a), int'(d), int'(8'(8'h11 * (a + 1))));
        end
        wr(A_MODE, 8'h09); rd(A_MODE, d); check("R2", "mode readback", int'(d), 8'h09);
        wr(A_SEL, 8'hFF);  rd(A_SEL, d);  check("R2", "select keeps 2 bits", int'(d), 3);
        wr(A_OE, 8'hFF);   rd(A_OE, d);   check("R2", "enable-out keeps N bits", int'(d), 8'h0F);
        wr(A_EN, 8'h05);   rd(A_EN, d);   check("R2", "run bits readback", int'(d), 8'h05);
        wr(A_EN, 8'h00);

        // R4 R5 R6 R7: vector table
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            tag = (v.mode == 2'd1) ? "R6" : (v.mode == 2'd2) ? "R7" :
                  (v.sel != 2'd0) ? "R5" : "R4";
            wr(A_EN, 8'h00);
            wr(A_FLAG, 8'hFF);
            wr(AW'(0), v.lo_e); wr(AW'(1), v.hi_e);
            wr(AW'(2), v.lo_o); wr(AW'(3), v.hi_o);
            wr(A_MODE, {6'b0, v.mode});
            wr(A_SEL, {6'b0, v.sel});
            wr(A_OE, 8'h0F);
            wr(A_EN, (v.mode == 2'd1) ? 8'h02 : 8'h03);
            measure(1, hi_len, lo_len);
            check(tag, $sformatf("vec %0d odd high", i), hi_len, int'(v.xhi_o));
            check(tag, $sformatf("vec %0d odd low", i), lo_len, int'(v.xlo_o));
            if (v.mode == 2'd0) begin
                measure(0, hi_len, lo_len);
                check(tag, $sformatf("vec %0d even high", i), hi_len, int'(v.xhi_e));
                check(tag, $sformatf("vec %0d even low", i), lo_len, int'(v.xlo_e));
            end else begin
                cnt = 0;
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    if (pwm_out[0]) cnt++;
                end
                check(tag, $sformatf("vec %0d even pin high samples", i), cnt, 0);
                rd(A_FLAG, d);
                check("R8", $sformatf("vec %0d chained flags", i), int'(d[1:0]), 2);
            end
        end
        wr(A_EN, 8'h00);

        // R3: first phase is low and of full width
        wr(A_MODE, 8'h00); wr(A_SEL, 8'h00); wr(A_OE, 8'h0F);
        wr(AW'(0), 8'd5); wr(AW'(1), 8'd2);
        wr(A_EN, 8'h01);
        cnt = 0;
        while (!pwm_out[0] && cnt < 50) begin cnt++; @(negedge clk); end
        check("R3", "first low length", cnt, 6);

        // R10: stop forces low, keeps reloads, restart is a full low phase
        wr(A_EN, 8'h00);
        check("R10", "pin after stop", int'(pwm_out[0]), 0);
        rd(AW'(0), d); check("R10", "low reload kept", int'(d), 5);
        rd(AW'(1), d); check("R10", "high reload kept", int'(d), 2);
        wr(A_EN, 8'h01);
        cnt = 0;
        while (!pwm_out[0] && cnt < 50) begin cnt++; @(negedge clk); end
        check("R10", "restart low length", cnt, 6);

        // R8 R9: flag timing, stickiness and clearing
        wr(A_EN, 8'h00); wr(A_FLAG, 8'hFF);
        wr(AW'(0), 8'd3); wr(AW'(1), 8'd2);
        wr(A_EN, 8'h01);
        check("R8", "irq at start", int'(irq), 0);
        while (!pwm_out[0]) @(negedge clk);
        check("R8", "irq during high", int'(irq), 0);
        while (pwm_out[0]) @(negedge clk);
        check("R8", "irq at high end", int'(irq), 1);
        wr(A_EN, 8'h00);
        rd(A_FLAG, d); check("R8", "flag bits", int'(d), 1);
        wr(A_FLAG, 8'h00); rd(A_FLAG, d); check("R9", "write 0 keeps flag", int'(d), 1);
        wr(A_FLAG, 8'h02); rd(A_FLAG, d); check("R9", "other bit keeps flag", int'(d), 1);
        wr(A_FLAG, 8'h01); rd(A_FLAG, d); check("R9", "write 1 clears flag", int'(d), 0);
        check("R9", "irq after clear", int'(irq), 0);

        // R11: output enable off holds pin low while counting goes on
        wr(AW'(2), 8'd1); wr(AW'(3), 8'd1);
        wr(A_OE, 8'h0D);
        wr(A_EN, 8'h02);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pwm_out[1]) cnt++;
        end
        check("R11", "masked pin high samples", cnt, 0);
        rd(A_FLAG, d); check("R11", "flag still sets", int'(d[1]), 1);
        wr(A_EN, 8'h00);

        summary();
        $finish;
    end

endmodule